// File: doc/BRIEF.md
# Phase Error Modulus Selector

This block sits beside a digital phase-locked loop and decides how aggressively the loop filter should react. It watches two single-bit signals, the loop's reference input and its feedback output. It counts how many system-clock cycles separate a rising edge of the reference from the next rising edge of the feedback. Each time such a count completes, the block puts it into one of three capture zones: fast, slow or synchronous. It then drives a 4-bit modulus control word for that zone, together with the filter modulus that the word selects.

A large phase error picks a short filter modulus. This gives coarse steps, wide bandwidth and quick pull-in. A small error picks a long modulus, which gives fine steps and better jitter rejection. A lock flag follows the synchronous zone. Both inputs pass through synchronizers of equal depth, so the cycle distance between their edges is kept.

The zone thresholds, the three zone words, the counter width and the synchronizer depth are parameters. A zone word of zero is passed through unchanged and means the loop filter is inhibited (modulus 0).

Top module: `pems_top`

## Requirements
- R1: While reset is held and after reset is released, the outputs are err_count = 0, ctrl_word = the fast-zone word (default 4'b0011), modulus = 32 and locked = 0.
- R2: A measurement window opens on a synchronized rising edge of ref_in. It closes on the next synchronized rising edge of fb_in. err_count then takes the number of clock cycles between the two edges, which is 0 when both edges fall in the same cycle. err_count changes only when a measurement completes.
- R3: A completed count greater than FAST_THR (default 3) selects the fast zone: ctrl_word = FAST_WORD (default 4'b0011), modulus = 32.
- R4: A completed count greater than SYNC_THR (default 1) and at most FAST_THR selects the slow zone: ctrl_word = SLOW_WORD (default 4'b0101), modulus = 128.
- R5: A completed count of at most SYNC_THR selects the synchronous zone: ctrl_word = SYNC_WORD (default 4'b1001), modulus = 2048, and locked = 1. In the other two zones locked is 0.
- R6: modulus equals 4 × 2^ctrl_word for words 1 through 15, and equals 0 for word 4'b0000, which means the filter is inhibited.
- R7: A rising edge of fb_in with no window open starts no measurement and leaves every output unchanged.
- R8: A rising edge of ref_in while a window is still open completes a measurement. The count is the elapsed cycles, which is one reference period. A new window opens at the same edge.
- R9: The running count saturates at 2^CNT_W − 1 and does not wrap.
- R10: ctrl_word, modulus and locked change only on the clock edge that follows a completed measurement. They hold between measurements.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| ref_in | input | 1 | Loop reference input, asynchronous |
| fb_in | input | 1 | Loop feedback output, asynchronous |
| err_count | output | CNT_W | Last completed phase error count, in clock cycles |
| ctrl_word | output | 4 | Modulus control word for the current zone |
| modulus | output | 18 | Filter modulus selected by ctrl_word |
| locked | output | 1 | High while in the synchronous zone |

## Verification
The bench builds two instances that share the same stimulus. The first uses the default parameters, so every threshold boundary (counts 0, 1, 2, 3, 4) falls on a few-cycle edge offset. The second uses a 6-bit counter, thresholds of 10 and 4, and a slow-zone word of zero. With these values, a 100-cycle reference period drives the counter into saturation at 63, and the inhibit word with its zero modulus appears at the ports. Both are otherwise out of reach with the defaults inside a short run.

// File: rtl/pems_pkg.sv
`timescale 1ns/1ps
package pems_pkg;
  localparam int WORD_W = 4;
  localparam int MOD_W  = 18;

  typedef enum logic [1:0] {ZONE_FAST, ZONE_SLOW, ZONE_SYNC} zone_e;

  // Classify a completed count against the two thresholds.
  function automatic zone_e classify(input logic [31:0] cnt,
                                     input int unsigned fast_thr,
                                     input int unsigned sync_thr);
    if (cnt > fast_thr)      return ZONE_FAST;
    else if (cnt > sync_thr) return ZONE_SLOW;
    else                     return ZONE_SYNC;
  endfunction

  // Filter modulus for a control word: four times two to the word, zero when inhibited.
  function automatic logic [MOD_W-1:0] modulus_of(input logic [WORD_W-1:0] w);
    logic [MOD_W-1:0] base;
    base = {{(MOD_W-3){1'b0}}, 3'b100};
    if (w == '0) return '0;
    return base << w;
  endfunction
endpackage

// File: rtl/pems_edge.sv
`timescale 1ns/1ps
module pems_edge #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sig_in,
  output logic rise
);
  logic [STAGES-1:0] sync_q;
  logic              prev_q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= sig_in;
      end
    end else begin : g_chain
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= {sync_q[STAGES-2:0], sig_in};
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= sync_q[STAGES-1];
  end

  assign rise = sync_q[STAGES-1] & ~prev_q;
endmodule

// File: rtl/pems_phase_counter.sv
`timescale 1ns/1ps
module pems_phase_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ref_rise,
  input  logic             fb_rise,
  output logic [CNT_W-1:0] err_count,
  output logic             meas_done
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
  localparam logic [CNT_W-1:0] CNT_ONE = {{(CNT_W-1){1'b0}}, 1'b1};

  logic             win_open;
  logic [CNT_W-1:0] run_cnt;
  logic             cnt_at_max;
  logic [CNT_W-1:0] run_next;

  assign cnt_at_max = (run_cnt == CNT_MAX);
  assign run_next   = cnt_at_max ? run_cnt : run_cnt + CNT_ONE;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      win_open  <= 1'b0;
      run_cnt   <= '0;
      err_count <= '0;
      meas_done <= 1'b0;
    end else begin
      meas_done <= 1'b0;
      if (ref_rise && fb_rise) begin
        err_count <= '0;
        meas_done <= 1'b1;
        win_open  <= 1'b0;
        run_cnt   <= '0;
      end else if (fb_rise && win_open) begin
        err_count <= run_cnt;
        meas_done <= 1'b1;
        win_open  <= 1'b0;
      end else if (ref_rise && win_open) begin
        err_count <= run_cnt;
        meas_done <= 1'b1;
        run_cnt   <= CNT_ONE;
      end else if (ref_rise) begin
        win_open  <= 1'b1;
        run_cnt   <= CNT_ONE;
      end else if (win_open) begin
        run_cnt   <= run_next;
      end
    end
  end
endmodule

// File: rtl/pems_zone_sel.sv
`timescale 1ns/1ps
module pems_zone_sel
  import pems_pkg::*;
#(
  parameter int unsigned      CNT_W     = 16,
  parameter int unsigned      FAST_THR  = 3,
  parameter int unsigned      SYNC_THR  = 1,
  parameter logic [WORD_W-1:0] FAST_WORD = 4'b0011,
  parameter logic [WORD_W-1:0] SLOW_WORD = 4'b0101,
  parameter logic [WORD_W-1:0] SYNC_WORD = 4'b1001
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              meas_done,
  input  logic [CNT_W-1:0]  err_count,
  output logic [WORD_W-1:0] ctrl_word,
  output logic [MOD_W-1:0]  modulus,
  output logic              locked
);
  zone_e             next_zone;
  logic [WORD_W-1:0] next_word;

  assign next_zone = classify(32'(err_count), FAST_THR, SYNC_THR);

  always_comb begin
    unique case (next_zone)
      ZONE_FAST: next_word = FAST_WORD;
      ZONE_SLOW: next_word = SLOW_WORD;
      default:   next_word = SYNC_WORD;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_word <= FAST_WORD;
      modulus   <= modulus_of(FAST_WORD);
      locked    <= 1'b0;
    end else if (meas_done) begin
      ctrl_word <= next_word;
      modulus   <= modulus_of(next_word);
      locked    <= (next_zone == ZONE_SYNC);
    end
  end
endmodule

// File: rtl/pems_top.sv
`timescale 1ns/1ps
module pems_top
  import pems_pkg::*;
#(
  parameter int unsigned       SYNC_STAGES = 2,
  parameter int unsigned       CNT_W       = 16,
  parameter int unsigned       FAST_THR    = 3,
  parameter int unsigned       SYNC_THR    = 1,
  parameter logic [WORD_W-1:0] FAST_WORD   = 4'b0011,
  parameter logic [WORD_W-1:0] SLOW_WORD   = 4'b0101,
  parameter logic [WORD_W-1:0] SYNC_WORD   = 4'b1001
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ref_in,
  input  logic              fb_in,
  output logic [CNT_W-1:0]  err_count,
  output logic [WORD_W-1:0] ctrl_word,
  output logic [MOD_W-1:0]  modulus,
  output logic              locked
);
  logic ref_rise;
  logic fb_rise;
  logic meas_done;

  pems_edge #(.STAGES(SYNC_STAGES)) u_ref_edge (
    .clk(clk), .rst_n(rst_n), .sig_in(ref_in), .rise(ref_rise)
  );

  pems_edge #(.STAGES(SYNC_STAGES)) u_fb_edge (
    .clk(clk), .rst_n(rst_n), .sig_in(fb_in), .rise(fb_rise)
  );

  pems_phase_counter #(.CNT_W(CNT_W)) u_count (
    .clk(clk), .rst_n(rst_n), .ref_rise(ref_rise), .fb_rise(fb_rise),
    .err_count(err_count), .meas_done(meas_done)
  );

  pems_zone_sel #(
    .CNT_W(CNT_W), .FAST_THR(FAST_THR), .SYNC_THR(SYNC_THR),
    .FAST_WORD(FAST_WORD), .SLOW_WORD(SLOW_WORD), .SYNC_WORD(SYNC_WORD)
  ) u_zone (
    .clk(clk), .rst_n(rst_n), .meas_done(meas_done), .err_count(err_count),
    .ctrl_word(ctrl_word), .modulus(modulus), .locked(locked)
  );
endmodule

// File: rtl/pems_chk.sv
`timescale 1ns/1ps
module pems_chk #(
  parameter int unsigned CNT_W     = 16,
  parameter int unsigned FAST_THR  = 3,
  parameter int unsigned SYNC_THR  = 1,
  parameter logic [3:0]  FAST_WORD = 4'b0011,
  parameter logic [3:0]  SLOW_WORD = 4'b0101,
  parameter logic [3:0]  SYNC_WORD = 4'b1001
) (
  input logic             clk,
  input logic             rst_n,
  input logic             meas_done,
  input logic [CNT_W-1:0] err_count,
  input logic [3:0]       ctrl_word,
  input logic             locked
);
  // R5
  lock_zone_chk: assert property (@(posedge clk) disable iff (!rst_n)
    locked |-> (ctrl_word == SYNC_WORD));

  // R3
  fast_pick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (meas_done && (32'(err_count) > FAST_THR)) |=> (ctrl_word == FAST_WORD));

  // R4
  slow_pick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (meas_done && (32'(err_count) > SYNC_THR) && (32'(err_count) <= FAST_THR))
      |=> (ctrl_word == SLOW_WORD));

  // R10
  hold_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !meas_done |=> $stable(ctrl_word) && $stable(locked));

  // R2
  hold_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !meas_done |-> $stable(err_count));
endmodule

bind pems_top pems_chk #(
  .CNT_W(CNT_W), .FAST_THR(FAST_THR), .SYNC_THR(SYNC_THR),
  .FAST_WORD(FAST_WORD), .SLOW_WORD(SLOW_WORD), .SYNC_WORD(SYNC_WORD)
) u_chk (
  .clk(clk), .rst_n(rst_n), .meas_done(meas_done), .err_count(err_count),
  .ctrl_word(ctrl_word), .locked(locked)
);

// File: tb/pems_top_tb.sv
`timescale 1ns/1ps
module pems_top_tb;
  localparam int A_CNT_W = 6;
  localparam int A_FAST  = 10;
  localparam int A_SYNC  = 4;
  localparam int A_SLOW_WORD = 0;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ref_in = 1'b0;
  logic fb_in = 1'b0;

  logic [15:0] m_err;  logic [3:0] m_word; logic [17:0] m_mod; logic m_lock;
  logic [5:0]  a_err;  logic [3:0] a_word; logic [17:0] a_mod; logic a_lock;

  always #2.5 clk = ~clk;

  pems_top u_dut (
    .clk(clk), .rst_n(rst_n), .ref_in(ref_in), .fb_in(fb_in),
    .err_count(m_err), .ctrl_word(m_word), .modulus(m_mod), .locked(m_lock)
  );

  pems_top #(.CNT_W(A_CNT_W), .FAST_THR(A_FAST), .SYNC_THR(A_SYNC),
             .SLOW_WORD(4'(A_SLOW_WORD))) u_alt (
    .clk(clk), .rst_n(rst_n), .ref_in(ref_in), .fb_in(fb_in),
    .err_count(a_err), .ctrl_word(a_word), .modulus(a_mod), .locked(a_lock)
  );

  typedef struct {
    int cnt; int word; int modv; int lk;
    int acnt; int aword; int amod; int alk;
    string req;
  } exp_t;

  exp_t sb_q[$];
  exp_t last_e;
  int n_tests = 0;
  int n_fail = 0;
  bit finished = 0;
  event chk_ev;

  function automatic int pick_word(int c, int fthr, int sthr, int fw, int sw, int yw);
    if (c > fthr) return fw;
    if (c > sthr) return sw;
    return yw;
  endfunction

  function automatic int mod_model(int w);
    return (w == 0) ? 0 : 4 * (2 ** w);
  endfunction

  function automatic exp_t model(int c, string req);
    exp_t e;
    int ac;
    ac = (c > 63) ? 63 : c;
    e.cnt   = (c > 65535) ? 65535 : c;
    e.word  = pick_word(e.cnt, 3, 1, 3, 5, 9);
    e.modv  = mod_model(e.word);
    e.lk    = (e.cnt <= 1) ? 1 : 0;
    e.acnt  = ac;
    e.aword = pick_word(ac, A_FAST, A_SYNC, 3, A_SLOW_WORD, 9);
    e.amod  = mod_model(e.aword);
    e.alk   = (ac <= A_SYNC) ? 1 : 0;
    e.req   = req;
    return e;
  endfunction

  task automatic cmp(string req, string what, int act, int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // Monitor: pops one expected item per trigger and compares both instances.
  initial begin
    forever begin
      exp_t e;
      @(chk_ev);
      if (sb_q.size() == 0) begin
        n_tests++; n_fail++;
        $display("FAIL scoreboard empty actual=0 expected=1");
      end else begin
        e = sb_q.pop_front();
        cmp(e.req, "main err_count", int'(m_err), e.cnt);
        cmp(e.req, "main ctrl_word", int'(m_word), e.word);
        cmp(e.req, "main modulus",   int'(m_mod), e.modv);
        cmp(e.req, "main locked",    int'(m_lock), e.lk);
        cmp(e.req, "alt err_count",  int'(a_err), e.acnt);
        cmp(e.req, "alt ctrl_word",  int'(a_word), e.aword);
        cmp(e.req, "alt modulus",    int'(a_mod), e.amod);
        cmp(e.req, "alt locked",     int'(a_lock), e.alk);
      end
    end
  end

  task automatic fire;
    #1;
    -> chk_ev;
    #1;
  endtask

  task automatic push(exp_t e);
    sb_q.push_back(e);
    last_e = e;
  endtask

  // One measurement: ref rises, fb rises d cycles later.
  task automatic meas(int d, string req);
    push(model(d, req));
    @(negedge clk); ref_in = 1'b1;
    if (d == 0) fb_in = 1'b1;
    repeat (d) @(negedge clk);
    fb_in = 1'b1;
    repeat (8) @(negedge clk);
    fire();
    ref_in = 1'b0; fb_in = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  initial begin
    exp_t e;
    // R1: reset state
    e = model(0, "R1"); e.word = 3; e.modv = 32; e.lk = 0; e.aword = 3; e.amod = 32; e.alk = 0;
    push(e);
    repeat (3) @(negedge clk);
    fire();
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    push(e);
    fire();

    meas(7, "R3 R2 R6");   // alt slow zone, inhibit word 0
    meas(3, "R4");
    meas(2, "R4");
    meas(1, "R5");
    meas(0, "R5 R2");
    meas(4, "R3");

    // R7: fb edge with no open window changes nothing
    push(last_e);
    @(negedge clk); fb_in = 1'b1;
    repeat (3) @(negedge clk); fb_in = 1'b0;
    repeat (8) @(negedge clk);
    last_e.req = "R7 R10"; sb_q[sb_q.size()-1].req = "R7 R10";
    fire();

    meas(12, "R3");

    // R8 R9: two ref edges 100 cycles apart, then fb 10 cycles later
    push(model(100, "R8 R9"));
    @(negedge clk); ref_in = 1'b1;
    repeat (3) @(negedge clk); ref_in = 1'b0;
    repeat (97) @(negedge clk); ref_in = 1'b1;
    repeat (8) @(negedge clk);
    fire();
    push(model(10, "R8 R6"));
    repeat (2) @(negedge clk); fb_in = 1'b1;
    repeat (8) @(negedge clk);
    fire();
    ref_in = 1'b0; fb_in = 1'b0;
    repeat (4) @(negedge clk);

    meas(1, "R5 R10");
    meas(5, "R3");

    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_tests++; n_fail++;
      $display("FAIL R2 watchdog actual=running expected=done");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule